// File: doc/BRIEF.md
# Cursor and Crosshair Overlay Generator

This block runs beside the pixel stream of a display controller and produces, for every pixel clock, a 2-bit overlay code. The code marks where a hardware cursor or a crosshair should be painted over the picture. The cursor is a 64x64 bitmap at 2 bits per pixel. It is held in an external 512-entry by 16-bit synchronous memory, which the block addresses itself. The crosshair is a pair of lines of selectable thickness. The lines cross at the cursor's reference point and are clipped to a programmable rectangle. The block works at one pixel per clock.

Position is tracked by two counters. The pixel counter restarts on each falling edge of horizontal sync. The line counter restarts on a falling edge of vertical sync and advances on each falling edge of horizontal sync. Cursor and window coordinates are given relative to these counters. The horizontal positions carry a fixed skew that the command word selects, and the vertical positions carry a fixed skew of 32 lines. A 7-bit command word does four things: it enables each source, chooses how the two sources merge, sets the crosshair thickness and selects the horizontal skew.

Top module: `ovl_cursor_xhair`

## Requirements
- R1: While reset is low, and after reset until the first sync edge, `ovl` is 0 whatever the command and coordinates are.
- R2: A falling edge of `hsync` seen at a clock edge E makes the pixel index 0 for the cycle that follows. The index then grows by one per clock. The overlay for pixel index n appears on `ovl` after clock edge E+n+2.
- R3: The cursor covers pixel indices cur_x+P to cur_x+P+63 and line indices cur_y+32 to cur_y+95. The skew P is 37 when `cmd[3:2]` is 00 or 11, 52 when it is 01 and 57 when it is 10.
- R4: While the pixel counter holds a pixel inside the cursor at cursor row r and column c, `mem_addr` equals r*8 + c/8 in that same cycle. The memory answers after one clock. The pixel uses bits [2k+1:2k] of the word, where k = c mod 8.
- R5: `cmd[6]` enables the cursor and `cmd[5]` enables the crosshair. With both bits at 0, `ovl` is 0.
- R6: The crosshair code is 3. The crosshair is hit when the pixel index lies within t of cur_x+P, or the line index lies within t of cur_y+32. Here t is `cmd[1:0]` (0 to 3), so the line widths are 1, 3, 5 and 7.
- R7: Crosshair hits count only inside the window. The window covers pixel indices win_x+P up to, but not including, win_x+P+win_w. It covers line indices win_y+32 up to, but not including, win_y+32+win_h. A window of zero width or zero height shows no crosshair.
- R8: When both sources are enabled, `cmd[4]`=1 gives the bitwise OR of the cursor code and the crosshair code, and `cmd[4]`=0 gives their AND. When only one source is enabled, its code is output unchanged. Outside the cursor the cursor code counts as 0, and off the crosshair the crosshair code counts as 0.
- R9: If falling edges of `vsync` and `hsync` arrive at the same clock edge, the line that follows has line index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Horizontal sync; its falling edge restarts the pixel counter |
| vsync | input | 1 | Vertical sync; its falling edge restarts the line counter |
| cmd | input | 7 | [6] cursor enable, [5] crosshair enable, [4] OR/AND merge, [3:2] skew select, [1:0] thickness |
| cur_x | input | 12 | Cursor horizontal position |
| cur_y | input | 12 | Cursor vertical position |
| win_x | input | 12 | Crosshair window left edge |
| win_y | input | 12 | Crosshair window top edge |
| win_w | input | 12 | Crosshair window width |
| win_h | input | 12 | Crosshair window height |
| mem_addr | output | 9 | Cursor bitmap word address |
| mem_rdata | input | 16 | Bitmap word, valid one clock after its address |
| ovl | output | 2 | Overlay code of the current pixel |

## Verification
Two events can land in the same clock cycle, and both cases are tested.

The first is a vertical sync fall together with a horizontal sync fall. The bench lowers both syncs at the same clock edge at the start of every frame. It judges the result through the rows on which the cursor appears and through the first cursor row in particular. A wrong line index would shift the whole bitmap vertically.

The second is a cursor pixel and a crosshair pixel on the same position. The crosshair passes through the cursor's top-left corner, so the two overlap there. The bench sweeps full frames in OR mode and in AND mode, with different skews and thicknesses. It compares every pixel against an arithmetic model of the merge.

// File: rtl/ovl_pkg.sv
// Shared types for the cursor/crosshair overlay generator.
// Assumes the command word layout stated in the brief (7 bits).
package ovl_pkg;

    // Decoded command word.
    typedef struct packed {
        logic       cur_en;   // bitmap cursor enable
        logic       xh_en;    // crosshair enable
        logic       or_mode;  // 1: OR merge, 0: AND merge
        logic [1:0] skew_sel; // horizontal skew select
        logic [1:0] thick;    // crosshair half-width
    } cmd_t;

    // Skew select codes.
    typedef enum logic [1:0] {
        SKEW_A   = 2'b00,
        SKEW_B   = 2'b01,
        SKEW_C   = 2'b10,
        SKEW_RSV = 2'b11
    } skew_e;

    // Split the raw command word into its fields.
    function automatic cmd_t decode_cmd(input logic [6:0] c);
        cmd_t d;
        d.cur_en   = c[6];
        d.xh_en    = c[5];
        d.or_mode  = c[4];
        d.skew_sel = c[3:2];
        d.thick    = c[1:0];
        return d;
    endfunction

endpackage

// File: rtl/ovl_timing.sv
// Sync edge detection and saturating pixel/line counters.
// Assumes syncs are already synchronous to clk. Counters reset to their
// maximum so nothing is drawn before the first sync edge.
module ovl_timing #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             vsync,
    output logic             hfall,
    output logic             vfall,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] vcnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hs_q;
    logic vs_q;

    assign hfall = hs_q & ~hsync;
    assign vfall = vs_q & ~vsync;

    // Remember the previous sync levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync;
            vs_q <= vsync;
        end
    end

    // Pixel counter: restart on hsync fall, otherwise count up and hold at max.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= CNT_MAX;
        end else if (hfall) begin
            hcnt <= '0;
        end else if (hcnt != CNT_MAX) begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Line counter: vsync fall wins over an hsync fall in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt <= CNT_MAX;
        end else if (vfall) begin
            vcnt <= '0;
        end else if (hfall && (vcnt != CNT_MAX)) begin
            vcnt <= vcnt + 1'b1;
        end
    end

endmodule

// File: rtl/ovl_cur_fetch.sv
// Bitmap cursor fetch. Stage 0 forms the word address from the live
// counters; the synchronous memory answers one clock later, when stage 1
// picks the 2-bit field. Assumes a memory with exactly one cycle of latency.
module ovl_cur_fetch #(
    parameter int CNT_W  = 14,
    parameter int SUM_W  = 15,
    parameter int CUR_LG = 6,
    parameter int WORD_W = 16
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [CNT_W-1:0]                           hcnt,
    input  logic [CNT_W-1:0]                           vcnt,
    input  logic [SUM_W-1:0]                           cx,
    input  logic [SUM_W-1:0]                           cy,
    output logic [2*CUR_LG-$clog2(WORD_W/2)-1:0]       mem_addr,
    input  logic [WORD_W-1:0]                          mem_rdata,
    output logic [1:0]                                 cur_code
);
    localparam int SEL_W = $clog2(WORD_W / 2);
    localparam int DIM   = 1 << CUR_LG;

    logic [SUM_W-1:0] hx, vy, dx, dy;
    logic             in_x, in_y;
    logic             s1_in;
    logic [SEL_W-1:0] s1_sel;
    logic [WORD_W-1:0] shifted;

    // Offsets of the current pixel from the cursor origin and the inside test.
    always_comb begin
        hx   = SUM_W'(hcnt);
        vy   = SUM_W'(vcnt);
        dx   = hx - cx;
        dy   = vy - cy;
        in_x = (hx >= cx) && (dx < SUM_W'(DIM));
        in_y = (vy >= cy) && (dy < SUM_W'(DIM));
    end

    // Word address: row-major, WORD_W/2 pixels per word.
    assign mem_addr = {dy[CUR_LG-1:0], dx[CUR_LG-1:SEL_W]};

    // Carry the inside flag and field index alongside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_in  <= 1'b0;
            s1_sel <= '0;
        end else begin
            s1_in  <= in_x & in_y;
            s1_sel <= dx[SEL_W-1:0];
        end
    end

    // Select the 2-bit field of the returned word, pixel 0 in the low bits.
    always_comb begin
        shifted  = mem_rdata >> {s1_sel, 1'b0};
        cur_code = s1_in ? shifted[1:0] : 2'b00;
    end

endmodule

// File: rtl/ovl_xhair.sv
// Crosshair hit test: two bands of width 2t+1 through (cx, cy), clipped to
// a window rectangle. Result is registered to align with the cursor fetch.
module ovl_xhair #(
    parameter int CNT_W   = 14,
    parameter int SUM_W   = 15,
    parameter int COORD_W = 12,
    parameter int Y_OFF   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   hcnt,
    input  logic [CNT_W-1:0]   vcnt,
    input  logic [SUM_W-1:0]   cx,
    input  logic [SUM_W-1:0]   cy,
    input  logic [SUM_W-1:0]   hoff,
    input  logic [1:0]         thick,
    input  logic [COORD_W-1:0] win_x,
    input  logic [COORD_W-1:0] win_y,
    input  logic [COORD_W-1:0] win_w,
    input  logic [COORD_W-1:0] win_h,
    output logic               xh_s1
);
    logic [SUM_W-1:0] hx, vy, half;
    logic [SUM_W-1:0] wx0, wx1, wy0, wy1;
    logic             vband, hband, inwin;

    // Band and window comparisons in widened arithmetic (no wrap).
    always_comb begin
        hx    = SUM_W'(hcnt);
        vy    = SUM_W'(vcnt);
        half  = SUM_W'(thick);
        wx0   = SUM_W'(win_x) + hoff;
        wx1   = wx0 + SUM_W'(win_w);
        wy0   = SUM_W'(win_y) + SUM_W'(Y_OFF);
        wy1   = wy0 + SUM_W'(win_h);
        vband = (hx + half >= cx) && (hx <= cx + half);
        hband = (vy + half >= cy) && (vy <= cy + half);
        inwin = (hx >= wx0) && (hx < wx1) && (vy >= wy0) && (vy < wy1);
    end

    // Register the hit so it lines up with the bitmap word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xh_s1 <= 1'b0;
        end else begin
            xh_s1 <= (vband | hband) & inwin;
        end
    end

endmodule

// File: rtl/ovl_mix.sv
// Merge stage: pipelines the enable/merge bits by one stage to match the
// data, combines the two sources and registers the overlay code.
module ovl_mix (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cur_en,
    input  logic       xh_en,
    input  logic       or_mode,
    input  logic [1:0] cur_code,
    input  logic       xh_hit,
    output logic [1:0] ovl
);
    logic       s1_cur_en, s1_xh_en, s1_or;
    logic [1:0] c_term, x_term, merged;

    // Delay the control bits to stage 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_cur_en <= 1'b0;
            s1_xh_en  <= 1'b0;
            s1_or     <= 1'b0;
        end else begin
            s1_cur_en <= cur_en;
            s1_xh_en  <= xh_en;
            s1_or     <= or_mode;
        end
    end

    // Pick the merged code: a lone enabled source passes through.
    always_comb begin
        c_term = cur_code;
        x_term = xh_hit ? 2'b11 : 2'b00;
        unique case ({s1_cur_en, s1_xh_en})
            2'b11:   merged = s1_or ? (c_term | x_term) : (c_term & x_term);
            2'b10:   merged = c_term;
            2'b01:   merged = x_term;
            default: merged = 2'b00;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl <= 2'b00;
        end else begin
            ovl <= merged;
        end
    end

endmodule

// File: rtl/ovl_cursor_xhair.sv
// Top of the cursor/crosshair overlay generator. One pixel per clock;
// overlay for a pixel appears two clocks after the counter holds it.
// Assumes all inputs are synchronous to clk and held steady within a line.
module ovl_cursor_xhair
    import ovl_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int CUR_LG  = 6,
    parameter int WORD_W  = 16,
    parameter int OFF_A   = 37,
    parameter int OFF_B   = 52,
    parameter int OFF_C   = 57,
    parameter int Y_OFF   = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 hsync,
    input  logic                                 vsync,
    input  logic [6:0]                           cmd,
    input  logic [COORD_W-1:0]                   cur_x,
    input  logic [COORD_W-1:0]                   cur_y,
    input  logic [COORD_W-1:0]                   win_x,
    input  logic [COORD_W-1:0]                   win_y,
    input  logic [COORD_W-1:0]                   win_w,
    input  logic [COORD_W-1:0]                   win_h,
    output logic [2*CUR_LG-$clog2(WORD_W/2)-1:0] mem_addr,
    input  logic [WORD_W-1:0]                    mem_rdata,
    output logic [1:0]                           ovl
);
    localparam int CNT_W = COORD_W + 2;
    localparam int SUM_W = COORD_W + 3;

    cmd_t             cf;
    logic [SUM_W-1:0] hoff, cx, cy;
    logic             hfall, vfall;
    logic [CNT_W-1:0] hcnt, vcnt;
    logic [1:0]       cur_code;
    logic             xh_s1;

    assign cf = decode_cmd(cmd);

    // Horizontal skew chosen by the command; the reserved code uses the first.
    always_comb begin
        unique case (skew_e'(cf.skew_sel))
            SKEW_B:  hoff = SUM_W'(OFF_B);
            SKEW_C:  hoff = SUM_W'(OFF_C);
            default: hoff = SUM_W'(OFF_A);
        endcase
    end

    // Cursor origin in counter space.
    always_comb begin
        cx = SUM_W'(cur_x) + hoff;
        cy = SUM_W'(cur_y) + SUM_W'(Y_OFF);
    end

    ovl_timing #(.CNT_W(CNT_W)) u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .hsync (hsync),
        .vsync (vsync),
        .hfall (hfall),
        .vfall (vfall),
        .hcnt  (hcnt),
        .vcnt  (vcnt)
    );

    ovl_cur_fetch #(
        .CNT_W (CNT_W),
        .SUM_W (SUM_W),
        .CUR_LG(CUR_LG),
        .WORD_W(WORD_W)
    ) u_cur (
        .clk      (clk),
        .rst_n    (rst_n),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .cx       (cx),
        .cy       (cy),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .cur_code (cur_code)
    );

    ovl_xhair #(
        .CNT_W  (CNT_W),
        .SUM_W  (SUM_W),
        .COORD_W(COORD_W),
        .Y_OFF  (Y_OFF)
    ) u_xh (
        .clk  (clk),
        .rst_n(rst_n),
        .hcnt (hcnt),
        .vcnt (vcnt),
        .cx   (cx),
        .cy   (cy),
        .hoff (hoff),
        .thick(cf.thick),
        .win_x(win_x),
        .win_y(win_y),
        .win_w(win_w),
        .win_h(win_h),
        .xh_s1(xh_s1)
    );

    ovl_mix u_mix (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_en  (cf.cur_en),
        .xh_en   (cf.xh_en),
        .or_mode (cf.or_mode),
        .cur_code(cur_code),
        .xh_hit  (xh_s1),
        .ovl     (ovl)
    );

endmodule

// File: rtl/ovl_cursor_xhair_chk.sv
// Property checker for the overlay generator, bound into the top module.
module ovl_cursor_xhair_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_hi,
    input logic             hfall,
    input logic             vfall,
    input logic [CNT_W-1:0] hcnt,
    input logic [CNT_W-1:0] vcnt,
    input logic             xh_s1,
    input logic [1:0]       ovl
);
    // R2: pixel counter restarts after an hsync fall.
    a_r2_hcnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        hfall |=> (hcnt == '0));

    // R2: pixel counter advances by one between restarts until saturation.
    a_r2_hcnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!hfall && !(&hcnt)) |=> (hcnt == $past(hcnt) + 1'b1));

    // R9: vsync fall forces line 0 even with a simultaneous hsync fall.
    a_r9_vsync_wins: assert property (@(posedge clk) disable iff (!rst_n)
        vfall |=> (vcnt == '0));

    // R1: a saturated pixel counter never yields overlay.
    a_r1_idle_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (&hcnt) |=> ##1 (ovl == 2'b00));

    // R5: both enables low blanks the output two clocks later.
    a_r5_blank_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hi[2:1] == 2'b00) |=> ##1 (ovl == 2'b00));

    // R8: OR merge with a crosshair hit gives code 3.
    a_r8_or_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cmd_hi) == 3'b111) && xh_s1) |=> (ovl == 2'b11));

    // R8: AND merge without a crosshair hit gives code 0.
    a_r8_and_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cmd_hi) == 3'b110) && !xh_s1) |=> (ovl == 2'b00));

endmodule

bind ovl_cursor_xhair ovl_cursor_xhair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_hi(cmd[6:4]),
    .hfall (hfall),
    .vfall (vfall),
    .hcnt  (hcnt),
    .vcnt  (vcnt),
    .xh_s1 (xh_s1),
    .ovl   (ovl)
);

// File: tb/tb_ovl_cursor_xhair.sv
`timescale 1ns/1ps
module tb_ovl_cursor_xhair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic [6:0]  cmd = '0;
    logic [11:0] cur_x = '0, cur_y = '0, win_x = '0, win_y = '0, win_w = '0, win_h = '0;
    logic [8:0]  mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [1:0]  ovl;

    logic [15:0] mem [512];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ovl_cursor_xhair dut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .cmd(cmd),
        .cur_x(cur_x), .cur_y(cur_y), .win_x(win_x), .win_y(win_y),
        .win_w(win_w), .win_h(win_h), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .ovl(ovl)
    );

    // Synchronous bitmap memory, one clock of latency.
    always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp,
                         input int h, input int v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s h=%0d v=%0d actual=%0d expected=%0d", req, h, v, act, exp);
        end
    endtask

    function automatic int skew();
        case (cmd[3:2])
            2'b01:   return 52;
            2'b10:   return 57;
            default: return 37;
        endcase
    endfunction

    function automatic bit in_cur(int h, int v);
        int cx = int'(cur_x) + skew();
        int cy = int'(cur_y) + 32;
        return (h >= cx) && (h < cx + 64) && (v >= cy) && (v < cy + 64);
    endfunction

    function automatic int exp_addr(int h, int v);
        int cx = int'(cur_x) + skew();
        int cy = int'(cur_y) + 32;
        return (v - cy) * 8 + (h - cx) / 8;
    endfunction

    function automatic bit in_band(int h, int v);
        int cx = int'(cur_x) + skew();
        int cy = int'(cur_y) + 32;
        int t  = int'(cmd[1:0]);
        return (h >= cx - t && h <= cx + t) || (v >= cy - t && v <= cy + t);
    endfunction

    function automatic bit in_win(int h, int v);
        int x0 = int'(win_x) + skew();
        int y0 = int'(win_y) + 32;
        return (h >= x0) && (h < x0 + int'(win_w)) && (v >= y0) && (v < y0 + int'(win_h));
    endfunction

    // Arithmetic model of the overlay code for pixel h on line v.
    function automatic int exp_ovl(int h, int v);
        int c = 0;
        int x = 0;
        if (in_cur(h, v)) begin
            int col = h - (int'(cur_x) + skew());
            c = int'((mem[exp_addr(h, v)] >> (2 * (col % 8))) & 16'd3);
        end
        if (in_band(h, v) && in_win(h, v)) x = 3;
        case ({cmd[6], cmd[5]})
            2'b11:   return cmd[4] ? (c | x) : (c & x);
            2'b10:   return c;
            2'b01:   return x;
            default: return 0;
        endcase
    endfunction

    // One frame: both syncs fall together on line 0, then one hsync fall per line.
    task automatic run_frame(input logic [6:0] c, input int cxv, input int cyv,
                             input int wx, input int wy, input int ww, input int wh,
                             input int nlines, input string ftag);
        int npix = 150;
        @(negedge clk);
        cmd = c; cur_x = 12'(cxv); cur_y = 12'(cyv);
        win_x = 12'(wx); win_y = 12'(wy); win_w = 12'(ww); win_h = 12'(wh);
        for (int l = 0; l < nlines; l++) begin
            @(negedge clk);
            hsync = 1'b1;
            if (l == 0) vsync = 1'b1;
            @(negedge clk);
            hsync = 1'b0;
            if (l == 0) vsync = 1'b0;
            for (int n = 0; n < npix; n++) begin
                @(negedge clk);
                if (in_cur(n, l)) begin
                    check(mem_addr == 9'(exp_addr(n, l)), "R4 addr", int'(mem_addr),
                          exp_addr(n, l), n, l);
                end
                if (n >= 2) begin
                    int h = n - 2;
                    int e = exp_ovl(h, l);
                    string tag = ftag;
                    if (l == cyv + 32) tag = "R9 first cursor row";
                    else if (h == cxv + skew()) tag = "R2 first cursor column";
                    else if (ftag == "R6" && in_band(h, l) && !in_win(h, l)) tag = "R7 clipped";
                    check(int'(ovl) == e, tag, int'(ovl), e, h, l);
                end
            end
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 512; a++) mem[a] = 16'((a * 40503) ^ (a << 7) ^ 16'h5a3c);
        // R1: reset and pre-sync state with everything enabled and a full window.
        cmd = 7'h70; win_w = 12'hfff; win_h = 12'hfff;
        repeat (3) @(negedge clk);
        check(ovl == 2'b00, "R1 in reset", int'(ovl), 0, -1, -1);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(ovl == 2'b00, "R1 before sync", int'(ovl), 0, -1, -1);
        end
        // R3: cursor only, first skew.
        run_frame(7'h40, 5, 1, 0, 0, 0, 0, 100, "R3");
        // R6/R7: crosshair only, thickness 3, window clips the bands.
        run_frame(7'h21, 20, 10, 2, 3, 90, 50, 90, "R6");
        // R8: OR merge, second skew, thickness 5.
        run_frame(7'h76, 10, 0, 0, 0, 100, 80, 100, "R8 or");
        // R8: AND merge, third skew, thickness 7.
        run_frame(7'h6B, 20, 3, 5, 10, 60, 70, 102, "R8 and");
        // R7: crosshair enabled but a zero window.
        run_frame(7'h33, 10, 5, 0, 0, 0, 0, 45, "R7 empty window");
        // R5: neither source enabled.
        run_frame(7'h1F, 0, 0, 0, 0, 200, 200, 40, "R5");
        // R3: reserved skew code behaves as the first skew.
        run_frame(7'h4C, 0, 0, 0, 0, 0, 0, 40, "R3 reserved skew");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule